// File: doc/BRIEF.md
# Parallel Programming Command Port

This block is the device-side logic of a pin-driven programming port for an on-chip nonvolatile store. The store is modelled here as small register arrays. An external programmer presents a two-bit action code, a byte-select line and an 8-bit data bus, then raises a load strobe to latch a command, an address byte or a data byte. A falling edge on the active-low write strobe starts whatever operation the latched command names. While that operation runs, the ready output is held low.

The latched command, address and data stay in place after an operation finishes. A programmer can therefore issue many writes or reads of one kind by reloading only the bytes that change. The address high byte selects a 256-location window and stays in force until it is reloaded.

Chip erase walks the program array one location per clock, then the data array unless the preserve input is high, and clears the lock byte last. A read-back path drives the location selected by the latched read command onto a data output.

Top module: `ppcmd_port`

## Requirements
- R1: After reset, rdy is 1, err is 0, the latched command is 8'h00, dout is 8'h00, and every program location, data location and the lock byte read as 8'hFF.
- R2: Loads happen only on a rising edge of ld_stb. act = 2'b10 with bsel = 0 latches dbus as the command. act = 2'b00 latches an address byte: the high byte when bsel = 1, the low byte when bsel = 0. act = 2'b01 latches the write data. act = 2'b10 with bsel = 1, and act = 2'b11, change nothing.
- R3: The command, address and data latches keep their values across operations, so repeated writes of one kind need only the changed bytes reloaded.
- R4: Loading only the low address byte keeps the previous high byte, so the access stays in the same 256-location window.
- R5: A falling edge of wr_n while rdy is 1 starts the latched command. The write commands are 8'h10 (program byte), 8'h11 (data byte) and 8'h20 (lock byte, new value = old AND data). Each write holds rdy low for exactly one cycle.
- R6: Command 8'h80 is chip erase. rdy is low for PM_DEPTH + DM_DEPTH + 1 cycles, or PM_DEPTH + 1 cycles when preserve is 1. The low period begins in the cycle after wr_n is sampled low.
- R7: After chip erase, every program location and the lock byte read 8'hFF. The lock byte is cleared only after the last program location has been cleared.
- R8: When preserve is 1, chip erase leaves the data array unchanged. When preserve is 0, every data location reads 8'hFF afterwards.
- R9: While rdy is 0, all loads are ignored and a wr_n falling edge is ignored. Such an edge sets err, which stays 1 until reset.
- R10: dout shows, without a clock delay, the program byte at the address when the command is 8'h02, the data byte when it is 8'h03, the lock byte when it is 8'h04, and 8'h00 for any other command.
- R11: A wr_n falling edge with any command other than 8'h10, 8'h11, 8'h20 or 8'h80 has no effect, and rdy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act | input | 2 | Action code for the next load |
| bsel | input | 1 | Byte select (address high/low, command qualifier) |
| dbus | input | 8 | Data bus carrying command, address or data |
| ld_stb | input | 1 | Load strobe, acts on its rising edge |
| wr_n | input | 1 | Write strobe, starts the operation on its falling edge |
| preserve | input | 1 | Keep the data array during chip erase |
| rdy | output | 1 | Ready (1) / busy (0) |
| err | output | 1 | Sticky flag: a write strobe arrived while busy |
| dout | output | 8 | Read-back byte selected by the latched read command |

## Verification
The hardest situation to reach is the middle of a chip erase. Only there can a load or a write strobe collide with a busy engine, and only after it can the ordering of the lock clear against the program walk be seen. The stimulus starts an erase and, while rdy is low, latches a read command and fires a second write strobe. Once ready returns, it reads back through the ports that the command did not change, that err is set, and that the preserved data byte survived. A second erase with preserve low then confirms the longer busy window and the cleared data array.

// File: rtl/ppcmd_pkg.sv
package ppcmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WR   = 3'd1,
    S_EPM  = 3'd2,
    S_EDM  = 3'd3,
    S_ELK  = 3'd4
  } seq_st_t;

  localparam logic [1:0] ACT_ADDR = 2'b00;
  localparam logic [1:0] ACT_DATA = 2'b01;
  localparam logic [1:0] ACT_CMD  = 2'b10;

  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_WR_PM = 8'h10;
  localparam logic [7:0] CMD_WR_DM = 8'h11;
  localparam logic [7:0] CMD_WR_LK = 8'h20;
  localparam logic [7:0] CMD_RD_PM = 8'h02;
  localparam logic [7:0] CMD_RD_DM = 8'h03;
  localparam logic [7:0] CMD_RD_LK = 8'h04;
endpackage

// File: rtl/ppcmd_edge.sv
module ppcmd_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ~RISE;
    else        q <= sig;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = sig & ~q;
    end else begin : g_fall
      assign pulse = ~sig & q;
    end
  endgenerate
endmodule

// File: rtl/ppcmd_latch.sv
module ppcmd_latch
  import ppcmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    act,
  input  logic          bsel,
  input  logic [7:0]    dbus,
  output logic [7:0]    cmd,
  output logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic          cmd_en, ahi_en, alo_en, dat_en;
  logic [7:0]    cmd_n, data_n;
  logic [AW-1:0] addr_n;

  always_comb begin
    cmd_en = en && (act == ACT_CMD) && !bsel;
    ahi_en = en && (act == ACT_ADDR) && bsel;
    alo_en = en && (act == ACT_ADDR) && !bsel;
    dat_en = en && (act == ACT_DATA);
    cmd_n  = cmd_en ? dbus : cmd;
    data_n = dat_en ? dbus : data;
    addr_n = addr;
    if (ahi_en) addr_n[AW-1:8] = dbus[AW-9:0];
    if (alo_en) addr_n[7:0]    = dbus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= 8'h00;
      addr <= '0;
      data <= 8'hFF;
    end else begin
      cmd  <= cmd_n;
      addr <= addr_n;
      data <= data_n;
    end
  end
endmodule

// File: rtl/ppcmd_seq.sv
module ppcmd_seq
  import ppcmd_pkg::*;
#(
  parameter int PM_DEPTH = 512,
  parameter int DM_DEPTH = 512,
  localparam int PW = $clog2((PM_DEPTH > DM_DEPTH) ? PM_DEPTH : DM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [7:0]    cmd,
  input  logic          preserve,
  output logic          rdy,
  output logic          err,
  output logic          wr_pm,
  output logic          wr_dm,
  output logic          wr_lk,
  output logic          clr_pm,
  output logic          clr_dm,
  output logic          clr_lk,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] PM_LAST = PW'(PM_DEPTH - 1);
  localparam logic [PW-1:0] DM_LAST = PW'(DM_DEPTH - 1);

  seq_st_t       st, st_n;
  logic [PW-1:0] ptr_n;
  logic          err_n;

  always_comb begin
    st_n  = st;
    ptr_n = ptr;
    err_n = err | (go && (st != S_IDLE));
    unique case (st)
      S_IDLE: begin
        if (go) begin
          if (cmd == CMD_ERASE) begin
            st_n  = S_EPM;
            ptr_n = '0;
          end else if (cmd == CMD_WR_PM || cmd == CMD_WR_DM || cmd == CMD_WR_LK) begin
            st_n = S_WR;
          end
        end
      end
      S_WR: st_n = S_IDLE;
      S_EPM: begin
        if (ptr == PM_LAST) begin
          ptr_n = '0;
          st_n  = preserve ? S_ELK : S_EDM;
        end else begin
          ptr_n = ptr + 1'b1;
        end
      end
      S_EDM: begin
        if (ptr == DM_LAST) begin
          ptr_n = '0;
          st_n  = S_ELK;
        end else begin
          ptr_n = ptr + 1'b1;
        end
      end
      S_ELK: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ptr <= '0;
      err <= 1'b0;
    end else begin
      st  <= st_n;
      ptr <= ptr_n;
      err <= err_n;
    end
  end

  assign rdy    = (st == S_IDLE);
  assign wr_pm  = (st == S_WR) && (cmd == CMD_WR_PM);
  assign wr_dm  = (st == S_WR) && (cmd == CMD_WR_DM);
  assign wr_lk  = (st == S_WR) && (cmd == CMD_WR_LK);
  assign clr_pm = (st == S_EPM);
  assign clr_dm = (st == S_EDM);
  assign clr_lk = (st == S_ELK);
endmodule

// File: rtl/ppcmd_store.sv
module ppcmd_store
  import ppcmd_pkg::*;
#(
  parameter int PM_DEPTH = 512,
  parameter int DM_DEPTH = 512,
  parameter int AW       = 16,
  localparam int PW    = $clog2((PM_DEPTH > DM_DEPTH) ? PM_DEPTH : DM_DEPTH),
  localparam int PM_AW = $clog2(PM_DEPTH),
  localparam int DM_AW = $clog2(DM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_pm,
  input  logic          wr_dm,
  input  logic          wr_lk,
  input  logic          clr_pm,
  input  logic          clr_dm,
  input  logic          clr_lk,
  input  logic [PW-1:0] ptr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    rcmd,
  output logic [7:0]    rdata
);
  logic [7:0]       pm [PM_DEPTH];
  logic [7:0]       dm [DM_DEPTH];
  logic [7:0]       lock;
  logic [PM_AW-1:0] pm_ix;
  logic [DM_AW-1:0] dm_ix;

  assign pm_ix = addr[PM_AW-1:0];
  assign dm_ix = addr[DM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PM_DEPTH; i++) pm[i] <= 8'hFF;
    end else if (clr_pm) begin
      pm[ptr[PM_AW-1:0]] <= 8'hFF;
    end else if (wr_pm) begin
      pm[pm_ix] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DM_DEPTH; i++) dm[i] <= 8'hFF;
    end else if (clr_dm) begin
      dm[ptr[DM_AW-1:0]] <= 8'hFF;
    end else if (wr_dm) begin
      dm[dm_ix] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock <= 8'hFF;
    else if (clr_lk) lock <= 8'hFF;
    else if (wr_lk)  lock <= lock & wdata;
  end

  always_comb begin
    unique case (rcmd)
      CMD_RD_PM: rdata = pm[pm_ix];
      CMD_RD_DM: rdata = dm[dm_ix];
      CMD_RD_LK: rdata = lock;
      default:   rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/ppcmd_port.sv
module ppcmd_port
  import ppcmd_pkg::*;
#(
  parameter int PM_DEPTH = 512,
  parameter int DM_DEPTH = 512,
  parameter int AW       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] act,
  input  logic       bsel,
  input  logic [7:0] dbus,
  input  logic       ld_stb,
  input  logic       wr_n,
  input  logic       preserve,
  output logic       rdy,
  output logic       err,
  output logic [7:0] dout
);
  localparam int PW = $clog2((PM_DEPTH > DM_DEPTH) ? PM_DEPTH : DM_DEPTH);

  logic          ld_rise, wr_fall;
  logic [7:0]    cmd, data;
  logic [AW-1:0] addr;
  logic          wr_pm, wr_dm, wr_lk, clr_pm, clr_dm, clr_lk;
  logic [PW-1:0] ptr;

  ppcmd_edge #(.RISE(1'b1)) u_ld_edge (
    .clk(clk), .rst_n(rst_n), .sig(ld_stb), .pulse(ld_rise)
  );

  ppcmd_edge #(.RISE(1'b0)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .sig(wr_n), .pulse(wr_fall)
  );

  ppcmd_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .en(ld_rise && rdy),
    .act(act), .bsel(bsel), .dbus(dbus),
    .cmd(cmd), .addr(addr), .data(data)
  );

  ppcmd_seq #(.PM_DEPTH(PM_DEPTH), .DM_DEPTH(DM_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(wr_fall), .cmd(cmd), .preserve(preserve),
    .rdy(rdy), .err(err),
    .wr_pm(wr_pm), .wr_dm(wr_dm), .wr_lk(wr_lk),
    .clr_pm(clr_pm), .clr_dm(clr_dm), .clr_lk(clr_lk), .ptr(ptr)
  );

  ppcmd_store #(.PM_DEPTH(PM_DEPTH), .DM_DEPTH(DM_DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_pm(wr_pm), .wr_dm(wr_dm), .wr_lk(wr_lk),
    .clr_pm(clr_pm), .clr_dm(clr_dm), .clr_lk(clr_lk),
    .ptr(ptr), .addr(addr), .wdata(data), .rcmd(cmd), .rdata(dout)
  );
endmodule

// File: rtl/ppcmd_port_chk.sv
module ppcmd_port_chk #(
  parameter int PM_DEPTH = 512,
  parameter int DM_DEPTH = 512,
  localparam int PW = $clog2((PM_DEPTH > DM_DEPTH) ? PM_DEPTH : DM_DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rdy,
  input logic          err,
  input logic          wr_pm,
  input logic          wr_dm,
  input logic          wr_lk,
  input logic          clr_pm,
  input logic          clr_dm,
  input logic          clr_lk,
  input logic [PW-1:0] ptr
);
  // R5
  write_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pm || wr_dm || wr_lk) |=> rdy);

  // R6
  busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(!wr_n));

  // R7
  lock_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lk |-> ($past(clr_pm && ptr == PW'(PM_DEPTH - 1)) ||
                $past(clr_dm && ptr == PW'(DM_DEPTH - 1))));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R9
  err_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!rdy));

  // R7
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_pm, clr_dm, clr_lk, wr_pm, wr_dm, wr_lk}));
endmodule

bind ppcmd_port ppcmd_port_chk #(.PM_DEPTH(PM_DEPTH), .DM_DEPTH(DM_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rdy(rdy), .err(err),
  .wr_pm(wr_pm), .wr_dm(wr_dm), .wr_lk(wr_lk),
  .clr_pm(clr_pm), .clr_dm(clr_dm), .clr_lk(clr_lk), .ptr(ptr)
);

// File: tb/ppcmd_port_tb.sv
module ppcmd_port_tb;
  localparam int PM = 512;
  localparam int DM = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] act = 2'b11;
  logic       bsel = 1'b0;
  logic [7:0] dbus = 8'h00;
  logic       ld_stb = 1'b0;
  logic       wr_n = 1'b1;
  logic       preserve = 1'b0;
  logic       rdy, err;
  logic [7:0] dout;

  int vectors = 0;
  int fails = 0;
  int busy_cycles = 0;

  always #10 clk = ~clk;

  ppcmd_port #(.PM_DEPTH(PM), .DM_DEPTH(DM)) u_dut (
    .clk(clk), .rst_n(rst_n), .act(act), .bsel(bsel), .dbus(dbus),
    .ld_stb(ld_stb), .wr_n(wr_n), .preserve(preserve),
    .rdy(rdy), .err(err), .dout(dout)
  );

  // behavioural reference
  byte unsigned m_pm [PM];
  byte unsigned m_dm [DM];
  byte unsigned m_lock, m_cmd, m_data, m_op;
  int           m_addr, m_busy;
  bit           m_err, m_ldq, m_wrq, m_pres;

  task automatic m_reset();
    foreach (m_pm[i]) m_pm[i] = 8'hFF;
    foreach (m_dm[i]) m_dm[i] = 8'hFF;
    m_lock = 8'hFF; m_cmd = 8'h00; m_data = 8'hFF; m_op = 8'h00;
    m_addr = 0; m_busy = 0; m_err = 0; m_ldq = 0; m_wrq = 1; m_pres = 0;
  endtask

  task automatic m_finish_op();
    if (m_op == 8'h10) m_pm[m_addr % PM] = m_data;
    if (m_op == 8'h11) m_dm[m_addr % DM] = m_data;
    if (m_op == 8'h20) m_lock = m_lock & m_data;
    if (m_op == 8'h80) begin
      foreach (m_pm[i]) m_pm[i] = 8'hFF;
      if (!m_pres) foreach (m_dm[i]) m_dm[i] = 8'hFF;
      m_lock = 8'hFF;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      bit ld_r, wr_f;
      ld_r = ld_stb && !m_ldq;
      wr_f = !wr_n && m_wrq;
      if (m_busy > 0) begin
        if (wr_f) m_err = 1;
        m_busy--;
        if (m_busy == 0) m_finish_op();
      end else begin
        if (wr_f) begin
          m_op = m_cmd;
          if (m_cmd == 8'h80) begin
            m_pres = preserve;
            m_busy = PM + (preserve ? 0 : DM) + 1;
          end else if (m_cmd == 8'h10 || m_cmd == 8'h11 || m_cmd == 8'h20) begin
            m_busy = 1;
          end
        end
        if (ld_r) begin
          if (act == 2'b10 && !bsel) m_cmd = dbus;
          if (act == 2'b00 && bsel)  m_addr = (m_addr & 8'hFF) | (int'(dbus) << 8);
          if (act == 2'b00 && !bsel) m_addr = (m_addr & 16'hFF00) | int'(dbus);
          if (act == 2'b01)          m_data = dbus;
        end
      end
      m_ldq = ld_stb;
      m_wrq = wr_n;
    end
  end

  function automatic byte unsigned m_dout();
    case (m_cmd)
      8'h02:   return m_pm[m_addr % PM];
      8'h03:   return m_dm[m_addr % DM];
      8'h04:   return m_lock;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actv, expv, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(rdy == (m_busy == 0), "R6 rdy", rdy, m_busy == 0);
      check(err == m_err, "R9 err", err, m_err);
      if (m_busy == 0) check(dout == m_dout(), "R10 dout", dout, m_dout());
      if (!rdy) busy_cycles++;
    end
  end

  task automatic ld(input logic [1:0] a, input logic b, input logic [7:0] v);
    act = a; bsel = b; dbus = v; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_pulse();
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdy == 1'b1, "R1 rdy", rdy, 1);
    check(err == 1'b0, "R1 err", err, 0);
    check(dout == 8'h00, "R1 dout", dout, 8'h00);
    ld(2'b10, 1'b0, 8'h02);
    check(dout == 8'hFF, "R1 erased pm", dout, 8'hFF);

    // R5 program byte writes, R3 command kept, R4 window kept
    ld(2'b10, 1'b0, 8'h10);
    ld(2'b00, 1'b1, 8'h00);
    ld(2'b00, 1'b0, 8'h05);
    ld(2'b01, 1'b0, 8'hA5);
    busy_cycles = 0;
    wr_pulse();
    wait_rdy();
    check(busy_cycles == 1, "R5 write busy", busy_cycles, 1);
    ld(2'b00, 1'b0, 8'h06);
    ld(2'b01, 1'b0, 8'h3C);
    wr_pulse();
    wait_rdy();
    ld(2'b00, 1'b1, 8'h01);
    ld(2'b00, 1'b0, 8'h05);
    ld(2'b01, 1'b0, 8'h77);
    wr_pulse();
    wait_rdy();
    ld(2'b10, 1'b0, 8'h02);
    ld(2'b00, 1'b1, 8'h00);
    ld(2'b00, 1'b0, 8'h05);
    check(dout == 8'hA5, "R3 first write", dout, 8'hA5);
    ld(2'b00, 1'b0, 8'h06);
    check(dout == 8'h3C, "R3 reused command", dout, 8'h3C);
    ld(2'b00, 1'b1, 8'h01);
    ld(2'b00, 1'b0, 8'h05);
    check(dout == 8'h77, "R4 window 1", dout, 8'h77);
    ld(2'b00, 1'b0, 8'h06);
    check(dout == 8'hFF, "R4 high byte kept", dout, 8'hFF);

    // R5 data and lock writes, R10 read selection
    ld(2'b10, 1'b0, 8'h11);
    ld(2'b00, 1'b1, 8'h00);
    ld(2'b00, 1'b0, 8'h09);
    ld(2'b01, 1'b0, 8'h5A);
    wr_pulse();
    wait_rdy();
    ld(2'b10, 1'b0, 8'h20);
    ld(2'b01, 1'b0, 8'hF0);
    wr_pulse();
    wait_rdy();
    ld(2'b01, 1'b0, 8'h3F);
    wr_pulse();
    wait_rdy();
    ld(2'b10, 1'b0, 8'h04);
    check(dout == 8'h30, "R5 lock and", dout, 8'h30);
    ld(2'b10, 1'b0, 8'h03);
    check(dout == 8'h5A, "R10 data read", dout, 8'h5A);

    // R2 ignored load codes
    ld(2'b10, 1'b1, 8'h04);
    ld(2'b11, 1'b0, 8'h04);
    check(dout == 8'h5A, "R2 ignored codes", dout, 8'h5A);

    // R11 unknown command
    ld(2'b10, 1'b0, 8'h55);
    busy_cycles = 0;
    wr_pulse();
    @(negedge clk);
    check(busy_cycles == 0, "R11 no busy", busy_cycles, 0);
    check(dout == 8'h00, "R10 non-read", dout, 8'h00);

    // R6 R7 R8 R9 erase with preserve, collisions while busy
    preserve = 1'b1;
    ld(2'b10, 1'b0, 8'h80);
    busy_cycles = 0;
    wr_pulse();
    ld(2'b10, 1'b0, 8'h03);
    wr_pulse();
    wait_rdy();
    check(busy_cycles == PM + 1, "R6 erase busy keep", busy_cycles, PM + 1);
    check(err == 1'b1, "R9 err set", err, 1);
    check(dout == 8'h00, "R9 load ignored", dout, 8'h00);
    ld(2'b10, 1'b0, 8'h03);
    check(dout == 8'h5A, "R8 data kept", dout, 8'h5A);
    ld(2'b10, 1'b0, 8'h04);
    check(dout == 8'hFF, "R7 lock cleared", dout, 8'hFF);
    ld(2'b10, 1'b0, 8'h02);
    ld(2'b00, 1'b0, 8'h05);
    check(dout == 8'hFF, "R7 pm cleared", dout, 8'hFF);

    // R6 R8 erase without preserve
    preserve = 1'b0;
    ld(2'b10, 1'b0, 8'h80);
    busy_cycles = 0;
    wr_pulse();
    wait_rdy();
    check(busy_cycles == PM + DM + 1, "R6 erase busy full", busy_cycles, PM + DM + 1);
    ld(2'b10, 1'b0, 8'h03);
    ld(2'b00, 1'b0, 8'h09);
    check(dout == 8'hFF, "R8 data cleared", dout, 8'hFF);
    check(err == 1'b1, "R9 err sticky", err, 1);

    // R1 reset clears err and command
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(err == 1'b0, "R1 err after reset", err, 0);
    check(dout == 8'h00, "R1 cmd after reset", dout, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule